// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer

This block is the master side of a multiplexed address/data bus. An internal requester hands it one access at a time: a start pulse, a read/write flag, a word count of one to four, an address, the write words and an atomic flag. The sequencer drives the address for one cycle and then runs one data cycle per word. It then holds the bus in recovery before going idle. The bus strobes are all active low: data-enable, last-transfer and lock. A direction output steers the data transceivers.

A single ready/recover input from the addressed device plays two roles. During data cycles, a high level adds a wait state and a low level completes the transfer. During recovery the sense flips: a low level keeps recovery going and a high level ends it. Read words come back on a separate port with a one-cycle valid pulse. An atomic request is issued as a read and then a write to the same address, with lock asserted across both accesses.

An external master may ask for the bus with a hold input. The grant is given only when the sequencer is idle or finishing recovery, and never while lock is asserted. While the grant is held, the drive enables for the address/data lines and the control strobes are low. A request that arrives during the grant is queued and starts as soon as the grant is dropped.

Top module: `bus_seq`

## Requirements
- R1: After reset, den_n, blast_n and lock_n are 1, holda, addr_strb and busy are 0, req_ready is 1, and ctl_oe is 1.
- R2: A request accepted (req_start high while req_ready is 1) at clock edge k gives one address cycle after edge k. In that cycle addr_strb=1, ad_oe=1, ad_out equals the request address, and dtr equals the effective write flag (1 = write).
- R3: den_n is 0 in every data cycle of an access, wait cycles included, and nowhere else. For an access of N words with W waits per word, it is low for exactly N*(W+1) cycles.
- R4: blast_n is 0 only in the data cycles of the final word (index N-1), wait cycles of that word included.
- R5: A data cycle with rdy_n=1 is a wait state: nothing advances and den_n and blast_n hold. A read word is captured from ad_in when rdy_n=0 and appears on rd_data with rd_valid=1 in the next cycle, in address order.
- R6: In a write data cycle, ad_oe=1 and ad_out carries word k of req_wdata (bits k*DW+DW-1 down to k*DW) for the k-th transfer.
- R7: After the last transfer the bus is in recovery. Recovery continues while rdy_n=0 and ends on the first cycle with rdy_n=1. busy stays 1 and no new address cycle starts during recovery.
- R8: For an atomic request, a read access is followed by a write access of the same address and length. lock_n is 0 from the read's address cycle through the write's final transfer, and is 1 in the cycle after that transfer.
- R9: holda never rises while lock_n is 0 or during an access. A grant is given only from idle or at the end of recovery.
- R10: While holda=1, ad_oe=0 and ctl_oe=0.
- R11: When hold drops, holda is 0 in the next cycle. That cycle is an address cycle if a request is pending; otherwise the block is idle.
- R12: dtr does not change between the address cycle and the release of den_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse for a new access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LW | Word count minus one |
| req_atomic | input | 1 | Locked read-then-write |
| req_addr | input | AW | Access address |
| req_wdata | input | MAXB*DW | Write words, word k in slice k |
| req_ready | output | 1 | A new request can be accepted |
| busy | output | 1 | A request is pending or running |
| rd_data | output | DW | Returned read word |
| rd_valid | output | 1 | rd_data valid pulse |
| ad_in | input | DW | Bus data sampled on reads |
| ad_out | output | DW | Bus address/data driven |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_strb | output | 1 | Address cycle indicator |
| den_n | output | 1 | Data-enable, active low |
| blast_n | output | 1 | Last-transfer strobe, active low |
| lock_n | output | 1 | Lock strobe, active low |
| dtr | output | 1 | Transceiver direction, 1 = write |
| ctl_oe | output | 1 | Drive enable for control strobes |
| rdy_n | input | 1 | Ready in data cycles, recover in recovery |
| hold | input | 1 | External bus request |
| holda | output | 1 | Bus grant to the external master |

## Verification
A wrong word index shows up in the data or transfer cycle where it occurs. The bench sees it at once as a misplaced blast_n, a wrong write word on ad_out, or a read word out of order on rd_data one cycle later. A state that ignores the changed meaning of rdy_n shows up as a recovery that is too short, which the bench sees as busy falling or an address cycle while recovery is still held. A lost lock or an early grant appears as holda high while lock_n is low, or as a grant between the two halves of an atomic pair. Such an error is seen no later than the cycle after the faulty transition.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_RECOV = 3'd3,
    ST_HOLD  = 3'd4
  } bus_st_e;
endpackage

// File: rtl/bus_seq_reqlat.sv
module bus_seq_reqlat #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int MAXB = 4,
  localparam int LW  = $clog2(MAXB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              req_write,
  input  logic [LW-1:0]     req_len,
  input  logic              req_atomic,
  input  logic [AW-1:0]     req_addr,
  input  logic [MAXB*DW-1:0] req_wdata,
  input  logic              phase_adv,
  input  logic              done,
  output logic              pending,
  output logic              phase,
  output logic              lat_write,
  output logic [LW-1:0]     lat_len,
  output logic              lat_atomic,
  output logic [AW-1:0]     lat_addr,
  output logic [MAXB*DW-1:0] lat_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      phase      <= 1'b0;
      lat_write  <= 1'b0;
      lat_len    <= '0;
      lat_atomic <= 1'b0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
    end else begin
      if (take) begin
        pending    <= 1'b1;
        phase      <= 1'b0;
        lat_write  <= req_write;
        lat_len    <= req_len;
        lat_atomic <= req_atomic;
        lat_addr   <= req_addr;
        lat_wdata  <= req_wdata;
      end else begin
        if (done)      pending <= 1'b0;
        if (phase_adv) phase   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_seq_beat.sv
module bus_seq_beat #(
  parameter int MAXB = 4,
  localparam int LW  = $clog2(MAXB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [LW-1:0] last_idx,
  output logic [LW-1:0] beat,
  output logic          is_last
);
  logic [LW-1:0] beat_d;

  always_comb begin
    beat_d = beat;
    if (clr)
      beat_d = '0;
    else if (adv && !is_last)
      beat_d = beat + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat <= '0;
    else        beat <= beat_d;
  end

  assign is_last = (beat == last_idx);
endmodule

// File: rtl/bus_seq_rdcap.sv
module bus_seq_rdcap #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= din;
    end
  end
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int MAXB = 4,
  localparam int LW  = $clog2(MAXB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic               req_write,
  input  logic [LW-1:0]      req_len,
  input  logic               req_atomic,
  input  logic [AW-1:0]      req_addr,
  input  logic [MAXB*DW-1:0] req_wdata,
  output logic               req_ready,
  output logic               busy,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  input  logic [DW-1:0]      ad_in,
  output logic [DW-1:0]      ad_out,
  output logic               ad_oe,
  output logic               addr_strb,
  output logic               den_n,
  output logic               blast_n,
  output logic               lock_n,
  output logic               dtr,
  output logic               ctl_oe,
  input  logic               rdy_n,
  input  logic               hold,
  output logic               holda
);
  bus_st_e st_q, st_d;
  logic    lock_q, lock_d;
  logic    pending, phase, lat_write, lat_atomic;
  logic [LW-1:0]      lat_len, beat;
  logic [AW-1:0]      lat_addr;
  logic [MAXB*DW-1:0] lat_wdata;
  logic    is_last, take, xfer, rec_end, first_half, done, phase_adv;
  logic    atom_in, start_addr;

  assign take       = req_start && !pending;
  assign xfer       = (st_q == ST_DATA) && !rdy_n;
  assign rec_end    = (st_q == ST_RECOV) && rdy_n;
  assign first_half = lat_atomic && !phase;
  assign done       = rec_end && !first_half;
  assign phase_adv  = rec_end && first_half;
  assign atom_in    = pending ? lat_atomic : req_atomic;

  bus_seq_reqlat #(.AW(AW), .DW(DW), .MAXB(MAXB)) u_req (
    .clk(clk), .rst_n(rst_n), .take(take),
    .req_write(req_write), .req_len(req_len), .req_atomic(req_atomic),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .phase_adv(phase_adv), .done(done),
    .pending(pending), .phase(phase), .lat_write(lat_write),
    .lat_len(lat_len), .lat_atomic(lat_atomic), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata)
  );

  bus_seq_beat #(.MAXB(MAXB)) u_beat (
    .clk(clk), .rst_n(rst_n), .clr(st_q == ST_ADDR), .adv(xfer),
    .last_idx(lat_len), .beat(beat), .is_last(is_last)
  );

  // effective direction: the atomic pair reads first, then writes
  assign dtr = lat_atomic ? phase : lat_write;

  bus_seq_rdcap #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .cap_en(xfer && !dtr), .din(ad_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold && !lock_q)           st_d = ST_HOLD;
        else if (pending || take)      st_d = ST_ADDR;
      end
      ST_ADDR:                         st_d = ST_DATA;
      ST_DATA:  if (xfer && is_last)   st_d = ST_RECOV;
      ST_RECOV: begin
        if (rdy_n) begin
          if (first_half)              st_d = ST_ADDR;
          else if (hold && !lock_q)    st_d = ST_HOLD;
          else                         st_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!hold)                     st_d = (pending || take) ? ST_ADDR : ST_IDLE;
      end
      default:                         st_d = ST_IDLE;
    endcase
  end

  assign start_addr = (st_q == ST_IDLE || st_q == ST_HOLD) && (st_d == ST_ADDR);

  always_comb begin
    lock_d = lock_q;
    if (start_addr && atom_in)
      lock_d = 1'b1;
    else if (xfer && is_last && lat_atomic && phase)
      lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_d;
    end
  end

  assign req_ready = !pending;
  assign busy      = pending;
  assign holda     = (st_q == ST_HOLD);
  assign ctl_oe    = !holda;
  assign addr_strb = (st_q == ST_ADDR);
  assign den_n     = !(st_q == ST_DATA);
  assign blast_n   = !((st_q == ST_DATA) && is_last);
  assign lock_n    = !lock_q;
  assign ad_oe     = addr_strb || ((st_q == ST_DATA) && dtr);
  assign ad_out    = addr_strb ? DW'(lat_addr) : lat_wdata[beat*DW +: DW];
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic rdy_n,
  input logic den_n,
  input logic blast_n,
  input logic lock_n,
  input logic holda,
  input logic ad_oe,
  input logic ctl_oe,
  input logic dtr,
  input logic addr_strb
);
  p_blast_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !blast_n |-> !den_n);

  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && rdy_n) |=> (!den_n && $stable(blast_n)));

  p_addr_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strb |=> !den_n);

  p_no_grant_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    holda |-> lock_n);

  p_grant_outside_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda) |-> $past(den_n) && !$past(addr_strb));

  p_float_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    holda |-> (!ad_oe && !ctl_oe));

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (holda && !hold) |=> !holda);

  p_dir_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> $stable(dtr));
endmodule

bind bus_seq bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .rdy_n(rdy_n), .den_n(den_n),
  .blast_n(blast_n), .lock_n(lock_n), .holda(holda), .ad_oe(ad_oe),
  .ctl_oe(ctl_oe), .dtr(dtr), .addr_strb(addr_strb)
);

// File: tb/bus_seq_tb.sv
module bus_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MAXB = 4;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0, req_write = 1'b0, req_atomic = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic [AW-1:0] req_addr = '0;
  logic [MAXB*DW-1:0] req_wdata = '0;
  logic req_ready, busy, rd_valid, ad_oe, addr_strb, den_n, blast_n, lock_n, dtr, ctl_oe, holda;
  logic [DW-1:0] rd_data, ad_out;
  logic [DW-1:0] ad_in = '0;
  logic rdy_n = 1'b1;
  logic hold = 1'b0;

  bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_len(req_len), .req_atomic(req_atomic), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .addr_strb(addr_strb), .den_n(den_n), .blast_n(blast_n),
    .lock_n(lock_n), .dtr(dtr), .ctl_oe(ctl_oe), .rdy_n(rdy_n),
    .hold(hold), .holda(holda)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    int            len;
    logic          atomic;
    logic [MAXB*DW-1:0] wdata;
  } acc_t;

  acc_t          acc_q[$];
  logic [DW-1:0] rd_q[$];
  acc_t cur;
  int checks = 0, fails = 0;
  int wait_cfg = 0, rec_cfg = 0;
  int wcnt = 0, rcnt = 0, beat_seen = 0, den_cnt = 0;
  bit lock_chk = 0, holda_prev = 0;
  int cyc = 0;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a, int k);
    return a * 3 + k * 32'h0101_0101 + 32'h5a;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // slave model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lock_chk) begin
        chk(lock_n == 1'b1, "R8 lock release", lock_n, 1);
        lock_chk = 0;
      end
      // ready/recover decision for this cycle
      if (!den_n && ctl_oe) begin
        if (wcnt < wait_cfg) begin rdy_n = 1'b1; wcnt++; end
        else begin rdy_n = 1'b0; wcnt = 0; ad_in = pat(cur.addr, beat_seen); end
      end else if (rcnt > 0) begin
        rdy_n = 1'b0; rcnt--;
        chk(busy && !addr_strb, "R7 recovery held", {busy, addr_strb}, 2'b10);
      end else rdy_n = 1'b1;

      if (addr_strb) begin
        if (acc_q.size() == 0) chk(0, "R2 unexpected address", ad_out, 0);
        else begin
          cur = acc_q.pop_front();
          chk(ad_out == cur.addr && ad_oe, "R2 address", ad_out, cur.addr);
          chk(dtr == cur.wr, "R2 direction", dtr, cur.wr);
          chk(lock_n == !cur.atomic, "R8 lock at address", lock_n, !cur.atomic);
        end
        beat_seen = 0; den_cnt = 0;
      end
      if (!den_n) begin
        den_cnt++;
        chk(blast_n == !(beat_seen == cur.len - 1), "R4 blast", blast_n, !(beat_seen == cur.len - 1));
        chk(dtr == cur.wr, "R12 direction steady", dtr, cur.wr);
        if (!rdy_n) begin
          if (cur.wr)
            chk(ad_oe && ad_out == cur.wdata[beat_seen*DW +: DW], "R6 write word",
                ad_out, cur.wdata[beat_seen*DW +: DW]);
          if (beat_seen == cur.len - 1) begin
            chk(den_cnt == cur.len * (wait_cfg + 1), "R3 data-enable length", den_cnt, cur.len * (wait_cfg + 1));
            rcnt = rec_cfg;
            if (cur.atomic && cur.wr) lock_chk = 1;
          end
          beat_seen++;
        end
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(0, "R5 unexpected read", rd_data, 0);
        else begin
          logic [DW-1:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R5 read data", rd_data, e);
        end
      end
      if (holda && !holda_prev) begin
        chk(lock_n && !busy, "R9 grant when unlocked", {lock_n, busy}, 2'b10);
        chk(!ad_oe && !ctl_oe, "R10 float", {ad_oe, ctl_oe}, 0);
      end
      holda_prev = holda;
    end
  end

  task automatic push_acc(logic [AW-1:0] a, logic w, int n, logic at, logic [MAXB*DW-1:0] wd);
    acc_t x;
    x.addr = a; x.wr = w; x.len = n; x.atomic = at; x.wdata = wd;
    acc_q.push_back(x);
    if (!w) for (int k = 0; k < n; k++) rd_q.push_back(pat(a, k));
  endtask

  // driver: push expected items and pulse the request
  task automatic issue(logic [AW-1:0] a, logic w, int n, logic at, logic [MAXB*DW-1:0] wd);
    while (!req_ready) @(negedge clk);
    if (at) begin
      push_acc(a, 1'b0, n, 1'b1, wd);
      push_acc(a, 1'b1, n, 1'b1, wd);
    end else push_acc(a, w, n, 1'b0, wd);
    req_addr = a; req_write = w; req_len = LW'(n - 1); req_atomic = at; req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(den_n && blast_n && lock_n && !holda && !addr_strb && !busy && req_ready && ctl_oe,
        "R1 reset state", {den_n, blast_n, lock_n, holda, addr_strb, busy, req_ready, ctl_oe}, 8'b1110_0011);
    rst_n = 1'b1;
    @(negedge clk);

    wait_cfg = 0; rec_cfg = 0;
    issue(32'h0000_1000, 1'b0, 1, 1'b0, '0); wait_idle();

    wait_cfg = 2; rec_cfg = 2;
    issue(32'h0000_2040, 1'b0, 4, 1'b0, '0); wait_idle();

    wait_cfg = 1; rec_cfg = 0;
    issue(32'h0000_3000, 1'b1, 3, 1'b0, {32'hdead_0003, 32'hdead_0002, 32'hdead_0001, 32'hdead_0000});
    wait_idle();

    wait_cfg = 0; rec_cfg = 3;
    issue(32'h0000_4400, 1'b1, 2, 1'b0, {64'h0, 32'hcafe_0001, 32'hcafe_0000});
    wait_idle();

    // atomic pair with a hold request raised mid-way: no grant until lock drops (R8, R9)
    wait_cfg = 1; rec_cfg = 1;
    issue(32'h0000_5000, 1'b0, 2, 1'b1, {64'h0, 32'hbeef_0001, 32'hbeef_0000});
    hold = 1'b1;
    while (!holda) @(negedge clk);
    chk(acc_q.size() == 0 && lock_n, "R9 grant after atomic pair", acc_q.size(), 0);
    hold = 1'b0;
    @(negedge clk);
    chk(!holda && !addr_strb, "R11 release to idle", {holda, addr_strb}, 0);
    wait_idle();

    // hold from idle with a queued request (R10, R11)
    wait_cfg = 0; rec_cfg = 0;
    hold = 1'b1;
    @(negedge clk);
    chk(holda == 1'b1, "R9 grant from idle", holda, 1);
    issue(32'h0000_6000, 1'b0, 3, 1'b0, '0);
    repeat (3) begin
      chk(holda && busy && !addr_strb, "R11 request waits for release", {holda, busy, addr_strb}, 3'b110);
      @(negedge clk);
    end
    hold = 1'b0;
    @(negedge clk);
    chk(!holda && addr_strb, "R11 release to address", {holda, addr_strb}, 2'b01);
    wait_idle();

    chk(acc_q.size() == 0 && rd_q.size() == 0, "R5 all results seen", rd_q.size(), 0);
    summary();
    $finish;
  end
endmodule